// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Controller

This block sits beside the time-of-day counters of a real-time clock and turns their activity into a host interrupt. Each counter stage sends a one-cycle increment strobe: hundredths, tenths, seconds, minutes, hours and days. The alarm comparator sends a one-cycle match pulse. Each of these events sets its own sticky flag in a status word. The flags are set whatever the mask says, so the status word always shows every source that has fired since the last time the host read it.

A single register address carries two registers. A host write to that address loads a source mask. A host read returns the status word, and the status word is cleared when the active-low read strobe ends. The interrupt request rises when the global enable input is 1 and some set flag has its mask bit set. In that same cycle, bit 7 of the status word becomes 1. This bit tells the host that this device raised the request. The counters, the comparator and the pin electrics are outside the block. The request is a logic-level output.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After synchronous reset, the mask is 00h, all eight status bits are 0 and `irq_req` is 0.
- R2: An increment strobe sets its status bit one clock later, whatever the mask holds. `alarm_match` sets bit 0. The strobes `cnt_tick[0..5]` set bits 1..6, in the order hundredths, tenths, seconds, minutes, hours, days.
- R3: `irq_req` rises only when `irq_en` is 1 and a set status flag has its mask bit set. Status bit 7 equals `irq_req` at all times.
- R4: While `bus_rd_n` is 0 and `bus_addr` is 10h, `bus_rdata` shows the status word. Any other address reads 00h, and a read of another address leaves the flags alone.
- R5: The status word holds steady while the strobe is low. One clock after `bus_rd_n` returns high from a read of 10h, all flags, bit 7 and `irq_req` are 0.
- R6: A source event in the same cycle as the clearing edge is kept. Its flag is set after the clear, and it can raise the request again.
- R7: A write strobe at 10h loads `bus_wdata[6:0]` into the mask; bit 7 of the written value is dropped. Writes to other addresses leave the mask unchanged.
- R8: If a flag is already set, then setting `irq_en` or its mask bit later raises `irq_req` on the next clock.
- R9: Writing 08h enables only the seconds source, and writing 00h blocks every source while the flags keep recording.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register address |
| bus_rd_n | input | 1 | Active-low read strobe, level |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 00h when the status register is not being read |
| irq_en | input | 1 | Global interrupt enable from the command register |
| cnt_tick | input | 6 | Counter increment strobes, hundredths to days |
| alarm_match | input | 1 | Alarm comparator match pulse |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
Two functions can fall in the same cycle: the clear that follows the end of a status read, and a new source event. The bench releases the read strobe in exactly the cycle that carries a seconds strobe, and in a second case a masked-off hundredths strobe. It then requires that the new flag is present afterwards and that the request follows the mask. A counter walk from hundredths = 57 with only the seconds source enabled must raise the request on the 43rd tick and again 100 ticks later. A mask write followed by tick strobes in the next cycle tests the other coincidence, where the mask is read and updated around the same edge.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

    localparam int TI_ADDR_W       = 5;
    localparam int TI_NUM_PERIODIC = 6;
    localparam logic [TI_ADDR_W-1:0] TI_REG_ADDR = 5'h10;

    // Bit positions within the status word; the host decodes these.
    typedef enum int {
        SRC_ALARM = 0,
        SRC_HUND  = 1,
        SRC_TENTH = 2,
        SRC_SEC   = 3,
        SRC_MIN   = 4,
        SRC_HOUR  = 5,
        SRC_DAY   = 6
    } src_pos_e;

    function automatic logic reg_select(
        input logic [TI_ADDR_W-1:0] addr,
        input logic [TI_ADDR_W-1:0] base
    );
        return addr == base;
    endfunction

endpackage

// File: rtl/tick_irq_host.sv
module tick_irq_host
    import tick_irq_pkg::*;
#(
    parameter int ADDR_W   = TI_ADDR_W,
    parameter int DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = TI_REG_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] rdata,
    output logic              mask_load,
    output logic              clr
);
    logic sel;
    logic reading;
    logic rd_hit_q;

    assign sel       = reg_select(addr, REG_ADDR);
    assign reading   = !rd_n && sel;
    assign mask_load = wr && sel;

    // rd_hit_q remembers a low strobe at the status address; the first
    // high strobe after it is the clearing edge.
    always_ff @(posedge clk) begin
        if (rst) rd_hit_q <= 1'b0;
        else     rd_hit_q <= reading;
    end

    assign clr   = rd_hit_q && rd_n;
    assign rdata = reading ? status_word : '0;

    assert_status_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (reading && $past(reading) && !$past(clr)) |-> (status_word & $past(status_word)) == $past(status_word));

endmodule

// File: rtl/tick_irq_flags.sv
module tick_irq_flags #(
    parameter int FLAG_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [FLAG_W-1:0] events,
    output logic [FLAG_W-1:0] flags_d,
    output logic [FLAG_W-1:0] flags_q
);
    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        // An event in the clearing cycle wins over the clear.
        assign flags_d[i] = events[i] | (flags_q[i] & !clr);

        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= 1'b0;
            else     flags_q[i] <= flags_d[i];
        end

        assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
            events[i] |=> flags_q[i]);
    end

    assert_clear_keeps_new_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> flags_q == $past(events));

endmodule

// File: rtl/tick_irq_gate.sv
module tick_irq_gate #(
    parameter int FLAG_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              mask_load,
    input  logic [FLAG_W-1:0] mask_in,
    input  logic [FLAG_W-1:0] flags_d,
    output logic [FLAG_W-1:0] mask_q,
    output logic              global_q
);
    logic hit;

    assign hit = en && (|(flags_d & mask_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            global_q <= 1'b0;
        end else begin
            if (mask_load) mask_q <= mask_in;
            global_q <= hit | (global_q & !clr);
        end
    end

    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(global_q) |-> $past(en));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !mask_load |=> $stable(mask_q));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
        (clr && !en) |=> !global_q);

endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
    import tick_irq_pkg::*;
#(
    parameter int ADDR_W       = TI_ADDR_W,
    parameter int NUM_PERIODIC = TI_NUM_PERIODIC,
    parameter logic [ADDR_W-1:0] REG_ADDR = TI_REG_ADDR,
    localparam int FLAG_W      = NUM_PERIODIC + 1,
    localparam int DATA_W      = NUM_PERIODIC + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_rd_n,
    input  logic                    bus_wr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic                    irq_en,
    input  logic [NUM_PERIODIC-1:0] cnt_tick,
    input  logic                    alarm_match,
    output logic                    irq_req
);
    logic [FLAG_W-1:0] events;
    logic [FLAG_W-1:0] flags_d;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] mask_q;
    logic [DATA_W-1:0] status_word;
    logic              global_q;
    logic              mask_load;
    logic              clr;
    logic              unused_wdata_top;

    assign events[SRC_ALARM]         = alarm_match;
    assign events[FLAG_W-1:SRC_HUND] = cnt_tick;
    assign status_word               = {global_q, flags_q};
    assign irq_req                   = global_q;
    assign unused_wdata_top          = bus_wdata[DATA_W-1];

    tick_irq_host #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR)
    ) u_host (
        .clk         (clk),
        .rst         (rst),
        .addr        (bus_addr),
        .rd_n        (bus_rd_n),
        .wr          (bus_wr),
        .status_word (status_word),
        .rdata       (bus_rdata),
        .mask_load   (mask_load),
        .clr         (clr)
    );

    tick_irq_flags #(.FLAG_W(FLAG_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .events  (events),
        .flags_d (flags_d),
        .flags_q (flags_q)
    );

    tick_irq_gate #(.FLAG_W(FLAG_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .en        (irq_en),
        .mask_load (mask_load),
        .mask_in   (bus_wdata[FLAG_W-1:0]),
        .flags_d   (flags_d),
        .mask_q    (mask_q),
        .global_q  (global_q)
    );

    assert_global_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n && bus_addr == REG_ADDR) |-> bus_rdata[DATA_W-1] == irq_req);

    assert_read_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n && bus_addr == REG_ADDR) |-> bus_rdata[FLAG_W-1:0] == flags_q);

    assert_irq_has_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> (|(flags_q & mask_q)));

endmodule

// File: tb/tick_irq_ctrl_tb.sv
module tick_irq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] bus_addr;
    logic       bus_rd_n;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_en;
    logic [5:0] cnt_tick;
    logic       alarm_match;
    logic       irq_req;

    always #4 clk = ~clk;

    tick_irq_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_rd_n    (bus_rd_n),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_en      (irq_en),
        .cnt_tick    (cnt_tick),
        .alarm_match (alarm_match),
        .irq_req     (irq_req)
    );

    typedef struct {
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // Reference state built from the requirements.
    logic [6:0] m_flags, m_mask;
    logic       m_glob, m_hit;
    logic       v_en;

    task automatic cycle(input logic [4:0] a, input logic rdn, input logic wr,
                         input logic [7:0] wd, input logic [5:0] tk, input logic al,
                         input string tag, input bit chk);
        logic       clr;
        logic [6:0] nf;
        logic       ng;
        @(negedge clk); #1;
        bus_addr = a; bus_rd_n = rdn; bus_wr = wr; bus_wdata = wd;
        cnt_tick = tk; alarm_match = al; irq_en = v_en;
        clr = m_hit && rdn;                                   // R5
        nf  = (clr ? 7'h00 : m_flags) | {tk, al};             // R2, R6
        ng  = (clr ? 1'b0 : m_glob) | (v_en && |(nf & m_mask)); // R3, R8
        if (wr && a == 5'h10) m_mask = wd[6:0];               // R7
        m_flags = nf;
        m_glob  = ng;
        m_hit   = !rdn && a == 5'h10;
        if (chk) q.push_back('{(!rdn && a == 5'h10) ? {ng, nf} : 8'h00, ng, tag});
    endtask

    task automatic idle(input string tag);
        cycle(5'h00, 1'b1, 1'b0, 8'h00, 6'h00, 1'b0, tag, 1'b1);
    endtask

    task automatic tick(input logic [5:0] tk, input logic al, input string tag);
        cycle(5'h00, 1'b1, 1'b0, 8'h00, tk, al, tag, 1'b1);
    endtask

    task automatic rd_low(input logic [4:0] a, input string tag);
        cycle(a, 1'b0, 1'b0, 8'h00, 6'h00, 1'b0, tag, 1'b1);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d, input string tag);
        cycle(a, 1'b1, 1'b1, d, 6'h00, 1'b0, tag, 1'b1);
    endtask

    // Full status read: low strobe, release, then one settle cycle.
    task automatic read_clear(input string tag);
        rd_low(5'h10, tag);
        idle(tag);
        idle(tag);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (bus_rdata !== e.rd || irq_req !== e.irq) begin
                n_bad++;
                $display("FAIL %s: rdata=%02h exp=%02h irq=%b exp=%b",
                         e.tag, bus_rdata, e.rd, irq_req, e.irq);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int h;
        rst = 1'b1; v_en = 1'b0;
        bus_addr = '0; bus_rd_n = 1'b1; bus_wr = 1'b0; bus_wdata = '0;
        cnt_tick = '0; alarm_match = 1'b0; irq_en = 1'b0;
        m_flags = '0; m_mask = '0; m_glob = 1'b0; m_hit = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd_low(5'h10, "R1 status after reset");
        idle("R1 idle after reset");

        // R1/R2: mask resets to 00h, so flags record without a request
        v_en = 1'b1;
        tick(6'b000100, 1'b0, "R2 seconds strobe, mask 00h");
        rd_low(5'h10, "R2 seconds flag bit 3");
        rd_low(5'h10, "R5 held during long strobe");
        idle("R5 release edge");
        rd_low(5'h10, "R5 cleared after release");
        idle("R5 idle");
        tick(6'b000000, 1'b1, "R2 alarm pulse");
        tick(6'b000011, 1'b0, "R2 hund and tenth strobes");

        // R4: another address reads 00h and does not clear
        rd_low(5'h11, "R4 other address reads zero");
        idle("R4 no clear from other address");
        read_clear("R4 flags survive foreign read");

        // R7: mask writes
        wr_reg(5'h11, 8'h7F, "R7 write other address ignored");
        tick(6'b111111, 1'b1, "R7 mask still 00h");
        read_clear("R7 clear");
        wr_reg(5'h10, 8'h88, "R7 load mask, bit 7 dropped");
        tick(6'b000001, 1'b0, "R9 hundredths not enabled by 08h");
        read_clear("R9 clear");

        // R3/R8: enable gating and late enable
        v_en = 1'b0;
        tick(6'b000100, 1'b0, "R3 masked source but enable 0");
        idle("R3 still low");
        v_en = 1'b1;
        idle("R8 late enable raises request");
        rd_low(5'h10, "R3 global bit 7 set");
        idle("R5 release drops request");
        idle("R5 request low");

        // R6: events in the clearing cycle
        rd_low(5'h10, "R6 read before coincident event");
        tick(6'b000100, 1'b0, "R6 seconds on clear edge");
        rd_low(5'h10, "R6 seconds flag kept");
        tick(6'b000001, 1'b0, "R6 hundredths on clear edge");
        rd_low(5'h10, "R6 hundredths flag kept, no request");
        idle("R6 release");
        idle("R6 settle");

        // R8: mask set later with pending flag
        wr_reg(5'h10, 8'h00, "R9 mask 00h");
        tick(6'b001000, 1'b0, "R9 minute strobe blocked");
        wr_reg(5'h10, 8'h10, "R8 late mask raises request");
        idle("R8 request held");
        read_clear("R8 clear");

        // R2/R3/R9: walk from hundredths = 57 with seconds only
        wr_reg(5'h10, 8'h08, "R9 seconds only");
        h = 57;
        for (int n = 0; n < 143; n++) begin
            int nh;
            logic [5:0] tk;
            nh = h + 1;
            tk = {3'b000, (nh == 100), (nh % 10 == 0), 1'b1};
            tick(tk, 1'b0, (n == 42 || n == 142) ? "R3 seconds request due" : "R3 walk");
            h = nh % 100;
            if (n == 42) read_clear("R3 service first request");
        end
        read_clear("R3 walk done");

        // R2: day rollover sets every periodic flag
        tick(6'b111111, 1'b0, "R2 day rollover");
        rd_low(5'h10, "R2 all periodic flags");
        idle("R2 release");

        // R9: 00h blocks everything while flags record
        wr_reg(5'h10, 8'h00, "R9 mask off");
        read_clear("R9 clear");
        tick(6'b111111, 1'b1, "R9 all sources blocked");
        rd_low(5'h10, "R9 flags still recorded");
        idle("R9 end");
        idle("R9 end");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule